// File: doc/BRIEF.md
# Card I/O Write Cycle Sequencer

This block is the host side of a single I/O-mode register write to a memory card over a parallel card bus. A client hands it one write request: an address, a 16-bit data word and a flag that selects the attribute/register space. The sequencer then runs the write on the bus. It drives the address, the active-low card enable, the active-low register select, the data bus with its output enable, and the active-low I/O write strobe. Every phase lasts a counted number of clock cycles, so every setup, pulse-width and hold minimum is met at the clock period the block is built for.

The request side is a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so the client must hold its request until it is taken. A request presented while the block is busy is not taken and has no effect. The card never stretches a cycle, so the length of a write is fixed. The phases run in this order: setup with everything driven and the strobe high, then the strobe low, then hold with the strobe high again, then one release cycle where the enable is dropped and the data bus is released. `done` pulses in the release cycle. The phase lengths are the ceiling of each minimum time divided by `CLK_NS`, and never less than one cycle. The setup phase uses the largest of the setup minimums and the hold phase the largest of the hold minimums.

Top module: `cio_write_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle. After that edge `bus_iowr_n`, `bus_ce_n` and `bus_reg_n` are 1, `bus_data_oe` is 0, `busy` and `done` are 0 and `req_ready` is 1. This holds even if the reset arrives in the middle of a write.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in idle. In the idle state `bus_iowr_n`, `bus_ce_n` and `bus_reg_n` are 1 and `bus_data_oe` is 0.
- R3: After the taking edge, the setup phase lasts max(1, ceil(max(70,60,5,5)/CLK_NS)) cycles, which is 7 at 10 ns. In setup `bus_addr` and `bus_data_o` carry the request, `bus_data_oe` is 1, `bus_ce_n` is 0 and `bus_iowr_n` is 1.
- R4: The strobe phase follows at once. `bus_iowr_n` is 0 for exactly max(1, ceil(165/CLK_NS)) cycles, which is 17 at 10 ns. `bus_ce_n` stays 0 and `bus_data_oe` stays 1.
- R5: The hold phase follows. It lasts max(1, ceil(max(20,30,20,0)/CLK_NS)) cycles, which is 3 at 10 ns. `bus_iowr_n` is 1, `bus_ce_n` is 0 and `bus_data_oe` is 1.
- R6: The hold phase is followed by exactly one release cycle. In it `bus_ce_n` and `bus_reg_n` are 1, `bus_data_oe` is 0 and `done` is 1. `done` is 0 in every other cycle. The next cycle is idle.
- R7: `busy` is 1 from the cycle after the taking edge through the release cycle, and `req_ready` is its inverse.
- R8: A request presented while `busy` is 1 is ignored. The bus outputs keep the values of the write in progress, and no extra write follows.
- R9: `bus_addr`, `bus_data_o` and `bus_reg_n` hold constant from the first setup cycle through the last hold cycle.
- R10: From setup through hold, `bus_reg_n` is 0 when the request flag `req_reg` was 1, and 1 when it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_reg | input | 1 | 1 selects the attribute/register space |
| bus_addr | output | ADDR_W | Card address bus |
| bus_data_o | output | DATA_W | Card data bus, out value |
| bus_data_oe | output | 1 | Data bus driven when 1, released when 0 |
| bus_ce_n | output | 1 | Card enable, active low |
| bus_reg_n | output | 1 | Register select, active low |
| bus_iowr_n | output | 1 | I/O write strobe, active low |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse in the release cycle |

## Verification
A wrong phase counter shows at the bus pins within one phase. The strobe would fall early or late against the first enabled cycle, its low width would differ from the computed count, or the release cycle would come at the wrong point. The bench compares every pin in every cycle of each write, so such a fault is seen in the first write that reaches the bad phase. A capture fault, such as taking a request while busy, shows as an address or data change inside the driven window, or as an extra write after `done`. A stuck state shows up right away: `req_ready` stays low, or the bus stays idle after a request is presented.

// File: rtl/cio_pkg.sv
package cio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_STROBE  = 3'd2,
    PH_HOLD    = 3'd3,
    PH_RELEASE = 3'd4
  } phase_t;

  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/cio_phase_timer.sv
module cio_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cio_phase_fsm.sv
module cio_phase_fsm
  import cio_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int SETUP_CYC  = 7,
  parameter int STROBE_CYC = 17,
  parameter int HOLD_CYC   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output phase_t           phase
);
  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  phase_t nxt;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = '0;
    unique case (phase)
      PH_IDLE: if (accept) begin
        nxt = PH_SETUP; load = 1'b1; load_val = SETUP_LD;
      end
      PH_SETUP: if (expired) begin
        nxt = PH_STROBE; load = 1'b1; load_val = STROBE_LD;
      end
      PH_STROBE: if (expired) begin
        nxt = PH_HOLD; load = 1'b1; load_val = HOLD_LD;
      end
      PH_HOLD: if (expired) begin
        nxt = PH_RELEASE; load = 1'b1;
      end
      PH_RELEASE: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end
endmodule

// File: rtl/cio_bus_drive.sv
module cio_bus_drive
  import cio_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_reg,
  input  phase_t            phase,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  output logic              bus_ce_n,
  output logic              bus_reg_n,
  output logic              bus_iowr_n,
  output logic              done
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              reg_q;
  logic              window;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      reg_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= in_addr;
      data_q <= in_data;
      reg_q  <= in_reg;
    end
  end

  assign window      = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign bus_addr    = addr_q;
  assign bus_data_o  = data_q;
  assign bus_data_oe = window;
  assign bus_ce_n    = !window;
  assign bus_reg_n   = !(window && reg_q);
  assign bus_iowr_n  = (phase != PH_STROBE);
  assign done        = (phase == PH_RELEASE);
endmodule

// File: rtl/cio_write_seq.sv
module cio_write_seq
  import cio_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_ADDR_SU = 70,
  parameter int T_ADDR_HD = 20,
  parameter int T_DATA_SU = 60,
  parameter int T_DATA_HD = 30,
  parameter int T_STB_W   = 165,
  parameter int T_CE_SU   = 5,
  parameter int T_CE_HD   = 20,
  parameter int T_REG_SU  = 5,
  parameter int T_REG_HD  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_reg,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  output logic              bus_ce_n,
  output logic              bus_reg_n,
  output logic              bus_iowr_n,
  output logic              busy,
  output logic              done
);
  localparam int SETUP_CYC  = ns_to_cyc(max4(T_ADDR_SU, T_DATA_SU, T_CE_SU, T_REG_SU), CLK_NS);
  localparam int STROBE_CYC = ns_to_cyc(T_STB_W, CLK_NS);
  localparam int HOLD_CYC   = ns_to_cyc(max4(T_ADDR_HD, T_DATA_HD, T_CE_HD, T_REG_HD), CLK_NS);
  localparam int MAX_CYC    = max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, 1);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  phase_t           phase;
  logic             accept;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;

  cio_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  cio_phase_fsm #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) fsm_i (
    .clk(clk), .rst(rst), .accept(accept), .expired(expired),
    .load(load), .load_val(load_val), .phase(phase)
  );

  cio_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) drive_i (
    .clk(clk), .rst(rst), .accept(accept),
    .in_addr(req_addr), .in_data(req_data), .in_reg(req_reg), .phase(phase),
    .bus_addr(bus_addr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_ce_n(bus_ce_n), .bus_reg_n(bus_reg_n), .bus_iowr_n(bus_iowr_n), .done(done)
  );
endmodule

// File: rtl/cio_write_seq_chk.sv
module cio_write_seq_chk #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 16,
  parameter int MIN_LOW = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              bus_iowr_n,
  input logic              bus_ce_n,
  input logic              bus_reg_n,
  input logic              bus_data_oe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data_o
);
  localparam int CW = $clog2(MIN_LOW + 2) + 1;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || bus_iowr_n) low_cnt <= '0;
    else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
  end

  assert_take_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);
  assert_strobe_framed_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_iowr_n |-> (!bus_ce_n && bus_data_oe));
  assert_enable_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_iowr_n) && !$past(rst)) |-> $past(!bus_ce_n && bus_data_oe));
  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_iowr_n) && !$past(rst)) |-> (low_cnt >= CW'(MIN_LOW)));
  assert_hold_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_iowr_n) && !$past(rst)) |-> (!bus_ce_n && bus_data_oe));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_release_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_ce_n && bus_reg_n && !bus_data_oe && busy));
  assert_window_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_n && $past(!bus_ce_n) && !$past(rst)) |->
      ($stable(bus_addr) && $stable(bus_data_o) && $stable(bus_reg_n)));
endmodule

bind cio_write_seq cio_write_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW(STROBE_CYC)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .bus_iowr_n(bus_iowr_n), .bus_ce_n(bus_ce_n),
  .bus_reg_n(bus_reg_n), .bus_data_oe(bus_data_oe), .bus_addr(bus_addr),
  .bus_data_o(bus_data_o)
);

// File: tb/cio_write_seq_tb.sv
module cio_write_seq_tb_top;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int PER = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int S = cyc(70);
  localparam int W = cyc(165);
  localparam int H = cyc(30);
  localparam int TOTAL = S + W + H + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_reg = 1'b0;
  logic req_ready, bus_data_oe, bus_ce_n, bus_reg_n, bus_iowr_n, busy, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cio_write_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_reg(req_reg),
    .bus_addr(bus_addr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_ce_n(bus_ce_n), .bus_reg_n(bus_reg_n), .bus_iowr_n(bus_iowr_n),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // bit order: ready busy done iowr_n ce_n reg_n oe
  function automatic logic [6:0] idle_vec();
    return 7'b1_0_0_1_1_1_0;
  endfunction

  function automatic logic [6:0] exp_vec(input int i, input bit r);
    if (i < S)          return {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, !r, 1'b1};
    if (i < S + W)      return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, !r, 1'b1};
    if (i < S + W + H)  return {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, !r, 1'b1};
    if (i == TOTAL - 1) return {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    return idle_vec();
  endfunction

  function automatic string tag_of(input int i);
    if (i < S)          return "R3";
    if (i < S + W)      return "R4";
    if (i < S + W + H)  return "R5";
    if (i == TOTAL - 1) return "R6";
    return "R2";
  endfunction

  function automatic logic [6:0] act_vec();
    return {req_ready, busy, done, bus_iowr_n, bus_ce_n, bus_reg_n, bus_data_oe};
  endfunction

  task automatic run_txn(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit r, input bit junk);
    @(negedge clk);
    check(req_ready === 1'b1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_data = d; req_reg = r;
    @(posedge clk);
    for (int i = 0; i <= TOTAL; i++) begin
      @(negedge clk);
      if (junk && i < TOTAL - 1) begin
        req_valid = 1'b1;
        req_addr  = AW'($urandom);
        req_data  = DW'($urandom);
        req_reg   = 1'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      check(act_vec() === exp_vec(i, r), junk ? "R8 R7 pins" : {tag_of(i), " R7 R10 pins"},
            {25'd0, act_vec()}, {25'd0, exp_vec(i, r)});
      if (i < S + W + H)
        check(bus_addr === a && bus_data_o === d, junk ? "R8 addr/data" : "R9 addr/data",
              {bus_addr, bus_data_o[15:0]}, {a, d[15:0]});
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(act_vec() === idle_vec(), "R1 reset state", {25'd0, act_vec()}, {25'd0, idle_vec()});

    // directed: both select polarities, extreme values
    run_txn('0, 16'h0000, 1'b0, 1'b0);
    run_txn('1, 16'hFFFF, 1'b1, 1'b0);
    // directed: requests during busy must be ignored
    run_txn(11'h2A5, 16'hA5C3, 1'b1, 1'b1);
    // idle stays idle with no request
    repeat (4) begin
      @(negedge clk);
      check(act_vec() === idle_vec(), "R2 idle hold", {25'd0, act_vec()}, {25'd0, idle_vec()});
    end

    // directed: reset in the middle of the strobe
    @(negedge clk);
    req_valid = 1'b1; req_addr = 11'h155; req_data = 16'h1234; req_reg = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (S + 4) @(negedge clk);
    check(bus_iowr_n === 1'b0, "R4 strobe low before reset", {31'd0, bus_iowr_n}, 32'd0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(act_vec() === idle_vec(), "R1 reset mid write", {25'd0, act_vec()}, {25'd0, idle_vec()});
    rst = 1'b0;

    // random writes with random gaps
    for (int k = 0; k < 40; k++) begin
      run_txn(AW'($urandom), DW'($urandom), 1'($urandom), ($urandom % 3) == 0);
      repeat ($urandom % 4) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule